// File: doc/BRIEF.md
# SPI controller FIFO and interrupt front end

This block is the register-side half of a single-channel SPI master. Software talks to it over a plain 32-bit register bus. Software pushes transmit words into an 8-deep queue and pops received words from a second 8-deep queue, both through one shared data offset. A small state machine hands transmit words to the serial engine over a valid/ready word interface. Received words from the engine land in the receive queue. The block also keeps sticky event flags, with a per-flag mask, that drive a single interrupt line.

The transmit hand-off state machine has two states. In TXH_IDLE no word is offered. In TXH_LOADED one word is held on the engine-facing outputs and `tx_valid` is high. The transitions are:
- **load**: TXH_IDLE to TXH_LOADED, when the block is enabled, the queue holds a word and no flush is happening.
- **reload**: TXH_LOADED to TXH_LOADED, when the engine accepts the held word and a further word is available while enabled.
- **drain**: TXH_LOADED to TXH_IDLE, when the engine accepts the word and no further word is loaded.
- **flush**: TXH_LOADED to TXH_IDLE, when a transmit flush discards the held word.

A typical use is as follows. Software flushes both queues, sets a receive threshold equal to the number of words it is about to send, writes those words and waits for the receive-complete interrupt. It then drains the receive queue.

Top module: `spi_front_top`

## Requirements
- R1: After reset, `irq`, `tx_valid` and `rx_ready` are 0. Reads of offsets 0x00, 0x14, 0x18, 0x1C and 0x20 return 0.
- R2: Words written to offset 0x24 reach `tx_data` in write order, one per valid/ready handshake. While `tx_valid` is high and `tx_ready` is low, the offered word stays unchanged.
- R3: The transmit queue holds 8 words. A write to 0x24 while it is full is discarded.
- R4: While control bit 0 (offset 0x00) is 0, `rx_ready` is 0 and no new transmit word is offered. Register accesses still work.
- R5: A read of 0x24 pops the oldest received word and returns it on `reg_rdata` in the cycle after the read strobe. A read while the receive queue is empty returns 0 and leaves the queue empty.
- R6: Bit 0 of offset 0x14 reads 1 exactly while the receive queue holds at least one word.
- R7: With receive threshold T (offset 0x20 bits 3:0) nonzero, the store that brings the receive queue to T words sets sticky bit 3 of 0x1C. Bit 9 of 0x1C reads 1 while the occupancy is at least T. With T = 0 neither bit is ever set.
- R8: A word offered on `rx_valid` while the receive queue holds 8 words is dropped and sets sticky bit 0 of 0x1C.
- R9: Sticky bit 4 of 0x1C is set when the engine accepts a word and the transmit queue is empty.
- R10: Writing 1 to bit 4, 3 or 0 of 0x1C clears that flag. Zeros leave flags unchanged. A flag event in the same cycle as its clear leaves the flag set.
- R11: `irq` is 1 exactly when some flag of 0x1C bits 4, 3, 0 is set and the matching enable bit of offset 0x18 (bits 4, 3, 0) is set.
- R12: Writing 1 to offset 0x20 bit 12 empties the transmit queue and withdraws any held word. Writing 1 to bit 4 empties the receive queue. Both bits read back as 0. The thresholds in bits 11:8 and 3:0 read back as written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rd | input | 1 | Register read strobe |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| tx_valid | output | 1 | Transmit word offered to the engine |
| tx_ready | input | 1 | Engine accepts the offered word |
| tx_data | output | DATA_W | Offered transmit word |
| rx_valid | input | 1 | Engine presents a received word |
| rx_ready | output | 1 | Block accepts received words |
| rx_data | input | DATA_W | Received word |
| irq | output | 1 | Masked interrupt request |

## Verification
The hold property of the transmit output applies only to cycles without a transmit flush. The bench therefore issues transmit flushes only while the controller is disabled and nothing is offered. The overrun and empty-read properties assume the engine side and the register strobes are known values at every clock edge. The bench drives every input at the falling edge and changes `tx_ready` shortly after the rising edge, so none of them moves near a sampling edge. The sweep covers every receive threshold from 0 to 8 against every occupancy from 1 to 8, and computes the expected flags from the threshold arithmetic.

// File: rtl/spi_front_pkg.sv
package spi_front_pkg;
    localparam int REG_W = 32;

    // register byte offsets
    localparam int OFS_CTL  = 'h00;
    localparam int OFS_SR   = 'h14;
    localparam int OFS_IE   = 'h18;
    localparam int OFS_IS   = 'h1C;
    localparam int OFS_FC   = 'h20;
    localparam int OFS_DATA = 'h24;

    // bit positions
    localparam int BIT_EN    = 0;
    localparam int BIT_RXNE  = 0;
    localparam int BIT_OVR   = 0;
    localparam int BIT_RC    = 3;
    localparam int BIT_TC    = 4;
    localparam int BIT_RXRS  = 9;
    localparam int BIT_RXFL  = 4;
    localparam int BIT_TXFL  = 12;
    localparam int RXTH_LSB  = 0;
    localparam int TXTH_LSB  = 8;

    typedef enum logic [0:0] {
        TXH_IDLE   = 1'b0,
        TXH_LOADED = 1'b1
    } txh_state_t;
endpackage

// File: rtl/spi_word_fifo.sv
module spi_word_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          flush,
    input  logic                          push,
    input  logic [W-1:0]                  wdata,
    input  logic                          pop,
    output logic [W-1:0]                  head,
    output logic [$clog2(DEPTH+1)-1:0]    count
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          full, empty, do_push, do_pop;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign head    = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wp] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else if (flush) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= step(wp);
            if (do_pop)  rp <= step(rp);
            unique case ({do_push, do_pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/spi_tx_holder.sv
module spi_tx_holder
    import spi_front_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         flush,
    input  logic         src_avail,
    input  logic [W-1:0] src_word,
    output logic         src_pop,
    output logic         tx_valid,
    input  logic         tx_ready,
    output logic [W-1:0] tx_data,
    output logic         drained
);
    txh_state_t state, state_nx;
    logic       load;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= TXH_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        load     = 1'b0;
        drained  = 1'b0;
        unique case (state)
            TXH_IDLE: begin
                if (!flush && en && src_avail) begin
                    state_nx = TXH_LOADED;
                    load     = 1'b1;
                end
            end
            TXH_LOADED: begin
                if (flush) begin
                    state_nx = TXH_IDLE;
                end else if (tx_ready) begin
                    drained = !src_avail;
                    if (en && src_avail) begin
                        load = 1'b1;
                    end else begin
                        state_nx = TXH_IDLE;
                    end
                end
            end
            default: state_nx = TXH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_data <= '0;
        end else if (load) begin
            tx_data <= src_word;
        end
    end

    assign src_pop  = load;
    assign tx_valid = (state == TXH_LOADED);
endmodule

// File: rtl/spi_irq_regs.sv
module spi_irq_regs (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ie_we,
    input  logic [2:0] ie_in,
    input  logic       clr_we,
    input  logic [2:0] clr_in,
    input  logic [2:0] set_in,
    output logic [2:0] ie,
    output logic [2:0] ist,
    output logic       irq
);
    logic [2:0] clr_mask;

    assign clr_mask = clr_we ? clr_in : 3'b000;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie  <= '0;
            ist <= '0;
        end else begin
            if (ie_we) ie <= ie_in;
            ist <= (ist & ~clr_mask) | set_in;
        end
    end

    assign irq = |(ist & ie);
endmodule

// File: rtl/spi_front_top.sv
module spi_front_top
    import spi_front_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 6,
    parameter int TH_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic              reg_rd,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [DATA_W-1:0] tx_data,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic [DATA_W-1:0] rx_data,
    output logic              irq
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int CMP_W = ((CNT_W > TH_W) ? CNT_W : TH_W) + 1;

    logic              ctl_en;
    logic [TH_W-1:0]   tx_thr, rx_thr;
    logic              sel_ctl, sel_sr, sel_ie, sel_is, sel_fc, sel_dat;
    logic              tx_flush, rx_flush, tx_push, rx_pop;
    logic [DATA_W-1:0] txq_head, rxq_head;
    logic [CNT_W-1:0]  tx_cnt, rx_cnt;
    logic              txq_pop, tx_drained;
    logic              rx_empty, rx_full, rx_store, rx_ovr_ev, rx_rc_ev, rx_rs;
    logic [CMP_W-1:0]  rx_cnt_x, rx_thr_x;
    logic [2:0]        ie, ist;
    logic [REG_W-1:0]  rd_mux;

    // address decode
    assign sel_ctl = (reg_addr == ADDR_W'(OFS_CTL));
    assign sel_sr  = (reg_addr == ADDR_W'(OFS_SR));
    assign sel_ie  = (reg_addr == ADDR_W'(OFS_IE));
    assign sel_is  = (reg_addr == ADDR_W'(OFS_IS));
    assign sel_fc  = (reg_addr == ADDR_W'(OFS_FC));
    assign sel_dat = (reg_addr == ADDR_W'(OFS_DATA));

    assign tx_flush = reg_wr && sel_fc && reg_wdata[BIT_TXFL];
    assign rx_flush = reg_wr && sel_fc && reg_wdata[BIT_RXFL];
    assign tx_push  = reg_wr && sel_dat;
    assign rx_pop   = reg_rd && sel_dat;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_en <= 1'b0;
            tx_thr <= '0;
            rx_thr <= '0;
        end else begin
            if (reg_wr && sel_ctl) ctl_en <= reg_wdata[BIT_EN];
            if (reg_wr && sel_fc) begin
                tx_thr <= reg_wdata[TXTH_LSB +: TH_W];
                rx_thr <= reg_wdata[RXTH_LSB +: TH_W];
            end
        end
    end

    // transmit path
    spi_word_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (tx_flush),
        .push  (tx_push),
        .wdata (reg_wdata[DATA_W-1:0]),
        .pop   (txq_pop),
        .head  (txq_head),
        .count (tx_cnt)
    );

    spi_tx_holder #(.W(DATA_W)) u_txh (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (ctl_en),
        .flush     (tx_flush),
        .src_avail (tx_cnt != '0),
        .src_word  (txq_head),
        .src_pop   (txq_pop),
        .tx_valid  (tx_valid),
        .tx_ready  (tx_ready),
        .tx_data   (tx_data),
        .drained   (tx_drained)
    );

    // receive path
    assign rx_ready  = ctl_en;
    assign rx_empty  = (rx_cnt == '0);
    assign rx_full   = (rx_cnt == CNT_W'(DEPTH));
    assign rx_store  = rx_valid && rx_ready && !rx_full && !rx_flush;
    assign rx_ovr_ev = rx_valid && rx_ready && rx_full;
    assign rx_cnt_x  = CMP_W'(rx_cnt);
    assign rx_thr_x  = CMP_W'(rx_thr);
    assign rx_rc_ev  = rx_store && (rx_thr != '0) && ((rx_cnt_x + CMP_W'(1)) == rx_thr_x);
    assign rx_rs     = (rx_thr != '0) && (rx_cnt_x >= rx_thr_x);

    spi_word_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (rx_flush),
        .push  (rx_valid && rx_ready),
        .wdata (rx_data),
        .pop   (rx_pop),
        .head  (rxq_head),
        .count (rx_cnt)
    );

    // event flags: [2]=tx complete, [1]=rx complete, [0]=overrun
    spi_irq_regs u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .ie_we  (reg_wr && sel_ie),
        .ie_in  ({reg_wdata[BIT_TC], reg_wdata[BIT_RC], reg_wdata[BIT_OVR]}),
        .clr_we (reg_wr && sel_is),
        .clr_in ({reg_wdata[BIT_TC], reg_wdata[BIT_RC], reg_wdata[BIT_OVR]}),
        .set_in ({tx_drained, rx_rc_ev, rx_ovr_ev}),
        .ie     (ie),
        .ist    (ist),
        .irq    (irq)
    );

    // read mux
    always_comb begin
        rd_mux = '0;
        if (sel_ctl) begin
            rd_mux[BIT_EN] = ctl_en;
        end else if (sel_sr) begin
            rd_mux[BIT_RXNE] = !rx_empty;
        end else if (sel_ie) begin
            rd_mux[BIT_TC]  = ie[2];
            rd_mux[BIT_RC]  = ie[1];
            rd_mux[BIT_OVR] = ie[0];
        end else if (sel_is) begin
            rd_mux[BIT_RXRS] = rx_rs;
            rd_mux[BIT_TC]   = ist[2];
            rd_mux[BIT_RC]   = ist[1];
            rd_mux[BIT_OVR]  = ist[0];
        end else if (sel_fc) begin
            rd_mux[TXTH_LSB +: TH_W] = tx_thr;
            rd_mux[RXTH_LSB +: TH_W] = rx_thr;
        end else if (sel_dat) begin
            if (!rx_empty) rd_mux[DATA_W-1:0] = rxq_head;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            reg_rdata <= rd_mux;
        end
    end
endmodule

// File: rtl/spi_front_checker.sv
module spi_front_checker
    import spi_front_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 6,
    parameter int CNT_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic              clr_rc_bit,
    input logic              reg_rd,
    input logic [REG_W-1:0]  reg_rdata,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic [DATA_W-1:0] tx_data,
    input logic              tx_flush,
    input logic              ctl_en,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic [CNT_W-1:0]  rx_cnt,
    input logic              ist_rc,
    input logic              ist_ovr
);
    assert_tx_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready && !tx_flush |=> tx_valid && $stable(tx_data));

    assert_no_offer_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_en && !tx_valid |=> !tx_valid);

    assert_empty_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd && (reg_addr == ADDR_W'(OFS_DATA)) && (rx_cnt == '0) |=> reg_rdata == '0);

    assert_ovr_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && rx_ready && (rx_cnt == CNT_W'(DEPTH)) |=> ist_ovr);

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_cnt <= CNT_W'(DEPTH));

    assert_rc_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ist_rc && !(reg_wr && (reg_addr == ADDR_W'(OFS_IS)) && clr_rc_bit) |=> ist_rc);
endmodule

bind spi_front_top spi_front_checker #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH),
    .ADDR_W (ADDR_W),
    .CNT_W  ($clog2(DEPTH + 1))
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_addr   (reg_addr),
    .reg_wr     (reg_wr),
    .clr_rc_bit (reg_wdata[3]),
    .reg_rd     (reg_rd),
    .reg_rdata  (reg_rdata),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .tx_data    (tx_data),
    .tx_flush   (tx_flush),
    .ctl_en     (ctl_en),
    .rx_valid   (rx_valid),
    .rx_ready   (rx_ready),
    .rx_cnt     (rx_cnt),
    .ist_rc     (ist[1]),
    .ist_ovr    (ist[0])
);

// File: tb/test_spi_front_top.sv
module test_spi_front_top;
    import spi_front_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_rdata;
    logic        tx_valid;
    logic        tx_ready = 1'b0;
    logic [31:0] tx_data;
    logic        rx_valid = 1'b0;
    logic        rx_ready;
    logic [31:0] rx_data = '0;
    logic        irq;

    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;
    int          tick = 0;
    bit          rdy_always = 1'b0;
    logic [31:0] got [64];
    int          n_got = 0;
    logic [31:0] v;

    always #5 clk = ~clk;

    spi_front_top i_spi_front_top (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .irq(irq)
    );

    function automatic logic [31:0] word(input int i);
        return 32'h1000_0000 + 32'(i) * 32'h0101_0103;
    endfunction

    // engine-side ready pattern, moved shortly after each rising edge
    always @(posedge clk) begin
        #2;
        tick++;
        tx_ready = rdy_always || (tick % 3 != 0);
    end

    // record handshakes that the next rising edge will complete
    always @(negedge clk) begin
        if (rst_n && tx_valid && tx_ready) begin
            if (n_got < 64) got[n_got] = tx_data;
            n_got++;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = 6'(a); reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = 6'(a); reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic push(input logic [31:0] d);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = d;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1: reset state
        check("R1 irq", 32'(irq), 0);
        check("R1 tx_valid", 32'(tx_valid), 0);
        check("R1 rx_ready", 32'(rx_ready), 0);
        rd(OFS_CTL, v); check("R1 ctl", v, 0);
        rd(OFS_SR, v);  check("R1 sr", v, 0);
        rd(OFS_IE, v);  check("R1 ie", v, 0);
        rd(OFS_IS, v);  check("R1 is", v, 0);
        rd(OFS_FC, v);  check("R1 fc", v, 0);

        // R3/R4: fill while disabled, 10 writes into an 8-deep queue
        for (int i = 0; i < 10; i++) wr(OFS_DATA, word(i));
        idle(5);
        check("R4 no offer while disabled", 32'(tx_valid), 0);
        check("R4 rx_ready low while disabled", 32'(rx_ready), 0);
        check("R4 nothing handed out", 32'(n_got), 0);
        wr(OFS_CTL, 1);
        check("R4 rx_ready after enable", 32'(rx_ready), 1);
        idle(40);
        check("R3 count delivered", 32'(n_got), 8);
        for (int i = 0; i < 8; i++) check("R2 order", got[i], word(i));
        rd(OFS_IS, v); check("R9 tx complete set", v & 32'h10, 32'h10);
        wr(OFS_IS, 32'h10);
        rd(OFS_IS, v); check("R10 tx complete cleared", v & 32'h10, 0);

        // R7/R6/R11/R12: threshold sweep
        for (int t = 0; t <= 8; t++) begin
            wr(OFS_FC, 32'h10 | 32'(t) | (32'(t) << 8));
            wr(OFS_IS, 32'h19);
            wr(OFS_IE, 32'h08);
            rd(OFS_FC, v); check("R12 fc readback", v, 32'(t) | (32'(t) << 8));
            rd(OFS_SR, v); check("R6 empty after flush", v, 0);
            for (int k = 1; k <= 8; k++) begin
                bit hit;
                hit = (t != 0) && (k >= t);
                push(word(100 + k));
                rd(OFS_IS, v);
                check("R7 rc/rxrs flags", v, hit ? 32'h208 : 32'h0);
                check("R11 irq follows rc", 32'(irq), 32'(hit));
                rd(OFS_SR, v); check("R6 not empty", v, 1);
            end
        end

        // R10: clear and event in the same cycle
        wr(OFS_FC, 32'h12);
        wr(OFS_IS, 32'h19);
        push(32'h55);
        @(negedge clk);
        reg_addr = 6'(OFS_IS); reg_wdata = 32'h08; reg_wr = 1'b1;
        rx_valid = 1'b1; rx_data = 32'h66;
        @(negedge clk);
        reg_wr = 1'b0; rx_valid = 1'b0;
        rd(OFS_IS, v); check("R10 event wins over clear", v, 32'h208);
        wr(OFS_IS, 32'h08);
        rd(OFS_IS, v); check("R10 clear leaves level bit", v, 32'h200);

        // R8/R5/R11: overrun and drain
        wr(OFS_FC, 32'h10);
        wr(OFS_IS, 32'h19);
        wr(OFS_IE, 32'h01);
        for (int i = 0; i < 9; i++) push(word(200 + i));
        check("R11 irq on overrun", 32'(irq), 1);
        rd(OFS_IS, v); check("R8 overrun flag", v, 32'h001);
        for (int i = 0; i < 8; i++) begin
            rd(OFS_DATA, v); check("R5 rx order", v, word(200 + i));
        end
        rd(OFS_DATA, v); check("R8 ninth word dropped", v, 0);
        rd(OFS_DATA, v); check("R5 empty read", v, 0);
        rd(OFS_SR, v);   check("R6 empty after drain", v, 0);
        wr(OFS_IS, 32'h01);
        check("R11 irq after clear", 32'(irq), 0);

        // R9/R2: short burst with engine always ready
        rdy_always = 1'b1;
        wr(OFS_DATA, word(300));
        wr(OFS_DATA, word(301));
        idle(10);
        check("R2 burst count", 32'(n_got), 10);
        check("R2 burst word 0", got[8], word(300));
        check("R2 burst word 1", got[9], word(301));
        rd(OFS_IS, v); check("R9 tx complete after burst", v & 32'h10, 32'h10);

        // R12: transmit flush
        wr(OFS_IS, 32'h19);
        wr(OFS_CTL, 0);
        for (int i = 0; i < 3; i++) wr(OFS_DATA, word(400 + i));
        wr(OFS_FC, 32'h1000);
        wr(OFS_CTL, 1);
        idle(10);
        check("R12 flushed words not sent", 32'(n_got), 10);
        check("R12 nothing offered", 32'(tx_valid), 0);
        rd(OFS_IS, v); check("R12 no tx complete", v & 32'h10, 0);
        rd(OFS_FC, v); check("R12 flush bit reads 0", v, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule